// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that runs its countdown from a separate slow clock, so that it keeps counting even if the main clock stops. Software talks to it through four small registers on the bus clock: a key register, a divider-code register, a reload register and a flag register. Three 16-bit key values act as commands. One refreshes ("feeds") the counter. One opens the divider and reload registers for writing. One starts the watchdog, and after that nothing but a block reset can stop it.

The slow clock is first divided by 4, 8, 16, 32, 64, 128 or 256, chosen by a 3-bit code, and each divided tick decrements a 12-bit counter. When the counter reaches zero, the reset output pulses for a fixed number of slow-clock cycles. The counter then stays idle until the block is reset. New divider and reload values pass into the slow domain through a toggle handshake. A pending flag for each value stays set until the slow side has taken the value, and while it is set, further writes to that register are dropped.

Top module: `iwdg_top`

## Requirements
- R1: After reset, the divider register (address 1) reads 0, the reload register (address 2) reads 0xFFF, the flag register (address 3) reads 0, and the key register (address 0) always reads 0. Write access is locked, and the reset output stays low for as long as no start key is written.
- R2: A write of 0x5555 to address 0 opens access. Writes to address 1 or 2 are ignored while access is closed. Writing any other value to address 0 closes access again.
- R3: An accepted divider write sets flag bit 0 in the next bus cycle. The flag clears on its own within 6 slow-clock periods.
- R4: An accepted reload write sets flag bit 1 in the next bus cycle. The flag clears on its own within 6 slow-clock periods.
- R5: A write to the divider or reload register while its own flag bit is set is ignored, and the register keeps its earlier value.
- R6: Writing 0xCCCC to address 0 loads the reload value and starts the count. With divider code c and reload value v, the reset output rises between (4·2^min(c,6))·v + 1 and (4·2^min(c,6))·v + 7 slow-clock cycles after the start write.
- R7: Writing 0xAAAA to address 0 while running reloads the counter. Feeding faster than the timeout prevents any reset. After the last feed, the reset rises within the R6 window measured from that feed.
- R8: Once started, the watchdog cannot be stopped by any key write, including 0x5555 and unknown values.
- R9: The reset output is high for exactly PULSE_LEN (4) slow-clock cycles. It then stays low until the block is reset, even if feeds follow.
- R10: Divider codes 6 and 7 both divide by 256.
- R11: A reload value of 0 gives a reset within 7 slow-clock cycles of the start write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| lclk | input | 1 | Independent slow counter clock |
| lrst | input | 1 | Synchronous active-high reset, slow domain |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 key, 1 divider, 2 reload, 3 flags |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 16 | Combinational read data; flags bit 0 divider pending, bit 1 reload pending |
| wdg_rst | output | 1 | Watchdog reset pulse, slow domain |

## Verification
The timeout is measured at several divider codes: 0, 2, 6 and 7, with reloads of 20, 10, 3 and 0. These runs tell apart the shift by the code, the clamp that makes codes 6 and 7 equal, and the zero-reload boundary. A feeding run shows that a feed really reloads the counter and does not merely delay the first tick. A run with stray keys after start shows that the running state is sticky. Locked writes and back-to-back writes are read back at the bus to separate key gating from the pending-flag gating.

// File: rtl/iwdg_pkg.sv
package iwdg_pkg;

    localparam int KEY_W      = 16;
    localparam int PR_W       = 3;
    localparam int PRESC_W    = 8;
    localparam int BASE_SHIFT = 2;
    localparam int MAX_SHIFT  = 6;

    localparam logic [KEY_W-1:0] KEY_FEED   = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_UNLOCK = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_START  = 16'hCCCC;

    typedef enum logic [1:0] {
        REG_KEY    = 2'd0,
        REG_DIV    = 2'd1,
        REG_RELOAD = 2'd2,
        REG_FLAGS  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        WD_IDLE,
        WD_RUN,
        WD_BITE,
        WD_HALT
    } wd_state_e;

    // Bus-to-slow crossing bundle: three toggles and one sticky level.
    typedef struct packed {
        logic feed;
        logic start;
        logic rl;
        logic pr;
    } xfer_t;

    // Last prescaler count value before a counter tick for a divider code.
    function automatic logic [PRESC_W-1:0] div_last(input logic [PR_W-1:0] code);
        int sh;
        sh = (int'(code) > MAX_SHIFT) ? MAX_SHIFT : int'(code);
        return PRESC_W'((1 << (sh + BASE_SHIFT)) - 1);
    endfunction

endpackage

// File: rtl/iwdg_sync.sv
module iwdg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stage[i] <= stage[i-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/iwdg_bus_regs.sv
module iwdg_bus_regs
    import iwdg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [1:0]           wr_addr,
    input  logic [KEY_W-1:0]     wr_data,
    input  logic                 ack_pr,
    input  logic                 ack_rl,
    output logic [PR_W-1:0]      pr_q,
    output logic [CNT_W-1:0]     rl_q,
    output xfer_t                xfer,
    output logic                 unlock,
    output logic                 pvu,
    output logic                 rvu
);
    localparam logic [CNT_W-1:0] RST_RELOAD = {CNT_W{1'b1}};

    // A pending flag is the mismatch between the sent toggle and the echo.
    assign pvu = xfer.pr ^ ack_pr;
    assign rvu = xfer.rl ^ ack_rl;

    always_ff @(posedge clk) begin
        if (rst) begin
            pr_q   <= '0;
            rl_q   <= RST_RELOAD;
            xfer   <= '0;
            unlock <= 1'b0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                REG_KEY: begin
                    unlock <= (wr_data == KEY_UNLOCK);
                    if (wr_data == KEY_FEED)  xfer.feed  <= ~xfer.feed;
                    if (wr_data == KEY_START) xfer.start <= 1'b1;
                end
                REG_DIV: begin
                    if (unlock && !pvu) begin
                        pr_q    <= wr_data[PR_W-1:0];
                        xfer.pr <= ~xfer.pr;
                    end
                end
                REG_RELOAD: begin
                    if (unlock && !rvu) begin
                        rl_q    <= wr_data[CNT_W-1:0];
                        xfer.rl <= ~xfer.rl;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/iwdg_core.sv
module iwdg_core
    import iwdg_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int PULSE_LEN = 4
) (
    input  logic              lclk,
    input  logic              lrst,
    input  xfer_t             xfer_s,
    input  logic [PR_W-1:0]   pr_val,
    input  logic [CNT_W-1:0]  rl_val,
    output logic              ack_pr,
    output logic              ack_rl,
    output logic              wdg_rst
);
    localparam int PW = $clog2(PULSE_LEN + 1);
    localparam logic [CNT_W-1:0] RST_RELOAD = {CNT_W{1'b1}};
    localparam logic [PW-1:0]    PULSE_END  = PW'(PULSE_LEN - 1);

    wd_state_e          state;
    logic [PR_W-1:0]    pr_cur;
    logic [CNT_W-1:0]   rl_cur;
    logic [CNT_W-1:0]   cnt;
    logic [PRESC_W-1:0] presc;
    logic [PW-1:0]      pulse_cnt;
    logic               pr_seen, rl_seen, feed_seen;
    logic               pr_evt, rl_evt, feed_evt, tick;

    assign pr_evt   = xfer_s.pr   != pr_seen;
    assign rl_evt   = xfer_s.rl   != rl_seen;
    assign feed_evt = xfer_s.feed != feed_seen;
    assign tick     = presc >= div_last(pr_cur);

    // The echo toggles in the same edge that captures the value.
    assign ack_pr  = pr_seen;
    assign ack_rl  = rl_seen;
    assign wdg_rst = (state == WD_BITE);

    always_ff @(posedge lclk) begin
        if (lrst) begin
            state     <= WD_IDLE;
            pr_cur    <= '0;
            rl_cur    <= RST_RELOAD;
            cnt       <= RST_RELOAD;
            presc     <= '0;
            pulse_cnt <= '0;
            pr_seen   <= 1'b0;
            rl_seen   <= 1'b0;
            feed_seen <= 1'b0;
        end else begin
            pr_seen   <= xfer_s.pr;
            rl_seen   <= xfer_s.rl;
            feed_seen <= xfer_s.feed;
            if (pr_evt) pr_cur <= pr_val;
            if (rl_evt) rl_cur <= rl_val;

            case (state)
                WD_IDLE: begin
                    if (xfer_s.start) begin
                        state <= WD_RUN;
                        cnt   <= rl_cur;
                        presc <= '0;
                    end
                end
                WD_RUN: begin
                    if (cnt == '0) begin
                        state     <= WD_BITE;
                        pulse_cnt <= '0;
                    end else if (feed_evt) begin
                        cnt   <= rl_cur;
                        presc <= '0;
                    end else if (tick) begin
                        presc <= '0;
                        cnt   <= cnt - 1'b1;
                    end else begin
                        presc <= presc + 1'b1;
                    end
                end
                WD_BITE: begin
                    if (pulse_cnt == PULSE_END) state <= WD_HALT;
                    else                         pulse_cnt <= pulse_cnt + 1'b1;
                end
                default: state <= WD_HALT;
            endcase
        end
    end
endmodule

// File: rtl/iwdg_top.sv
module iwdg_top
    import iwdg_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int PULSE_LEN   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lclk,
    input  logic              lrst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [KEY_W-1:0]  wr_data,
    input  logic [1:0]        rd_addr,
    output logic [KEY_W-1:0]  rd_data,
    output logic              wdg_rst
);
    localparam int XW = $bits(xfer_t);

    logic [PR_W-1:0]  pr_q;
    logic [CNT_W-1:0] rl_q;
    xfer_t            xfer_b;
    xfer_t            xfer_s;
    logic [XW-1:0]    xfer_s_raw;
    logic             unlock, pvu, rvu;
    logic             ack_pr_l, ack_rl_l;
    logic [1:0]       ack_b;

    iwdg_bus_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ack_pr  (ack_b[0]),
        .ack_rl  (ack_b[1]),
        .pr_q    (pr_q),
        .rl_q    (rl_q),
        .xfer    (xfer_b),
        .unlock  (unlock),
        .pvu     (pvu),
        .rvu     (rvu)
    );

    iwdg_sync #(.W(XW), .STAGES(SYNC_STAGES)) u_sync_to_slow (
        .clk (lclk),
        .rst (lrst),
        .d   (xfer_b),
        .q   (xfer_s_raw)
    );
    assign xfer_s = xfer_t'(xfer_s_raw);

    iwdg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync_to_bus (
        .clk (clk),
        .rst (rst),
        .d   ({ack_rl_l, ack_pr_l}),
        .q   (ack_b)
    );

    iwdg_core #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_core (
        .lclk    (lclk),
        .lrst    (lrst),
        .xfer_s  (xfer_s),
        .pr_val  (pr_q),
        .rl_val  (rl_q),
        .ack_pr  (ack_pr_l),
        .ack_rl  (ack_rl_l),
        .wdg_rst (wdg_rst)
    );

    always_comb begin
        case (reg_sel_e'(rd_addr))
            REG_DIV:    rd_data = {{(KEY_W-PR_W){1'b0}}, pr_q};
            REG_RELOAD: rd_data = {{(KEY_W-CNT_W){1'b0}}, rl_q};
            REG_FLAGS:  rd_data = {{(KEY_W-2){1'b0}}, rvu, pvu};
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/iwdg_checks.sv
module iwdg_checks
    import iwdg_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       lclk,
    input logic       lrst,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic       unlock,
    input logic [2:0] pr_q,
    input logic [11:0] rl_q,
    input logic       pvu,
    input logic       rvu,
    input logic       start_q,
    input logic       wdg_rst
);
    logic [7:0] hi_cnt;
    logic       done;

    always_ff @(posedge lclk) begin
        if (lrst) begin
            hi_cnt <= '0;
            done   <= 1'b0;
        end else begin
            if (wdg_rst) hi_cnt <= (hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 1'b1;
            else         hi_cnt <= '0;
            if ($fell(wdg_rst)) done <= 1'b1;
        end
    end

    // R2: locked writes leave the configuration untouched
    a_r2_locked_div: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'(REG_DIV) && !unlock) |=> $stable(pr_q));
    a_r2_locked_reload: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'(REG_RELOAD) && !unlock) |=> $stable(rl_q));
    // R3: accepted divider write raises its pending flag
    a_r3_pending_set: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'(REG_DIV) && unlock && !pvu) |=> pvu);
    // R5: writes during a pending transfer are dropped
    a_r5_busy_div: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'(REG_DIV) && pvu) |=> $stable(pr_q));
    a_r5_busy_reload: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'(REG_RELOAD) && rvu) |=> $stable(rl_q));
    // R8: running state is never left
    a_r8_sticky_start: assert property (@(posedge clk) disable iff (rst)
        start_q |=> start_q);
    // R9: pulse is bounded and occurs once
    a_r9_pulse_width: assert property (@(posedge lclk) disable iff (lrst)
        hi_cnt <= 8'(PULSE_LEN));
    a_r9_single_pulse: assert property (@(posedge lclk) disable iff (lrst)
        !(done && wdg_rst));
endmodule

bind iwdg_top iwdg_checks #(.PULSE_LEN(PULSE_LEN)) u_checks (
    .clk     (clk),
    .rst     (rst),
    .lclk    (lclk),
    .lrst    (lrst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .unlock  (unlock),
    .pr_q    (pr_q),
    .rl_q    (rl_q),
    .pvu     (pvu),
    .rvu     (rvu),
    .start_q (xfer_b.start),
    .wdg_rst (wdg_rst)
);

// File: tb/test_iwdg_top.sv
module test_iwdg_top;
    logic        clk = 0, lclk = 0;
    logic        rst = 1, lrst = 1;
    logic        wr_en = 0;
    logic [1:0]  wr_addr = 0, rd_addr = 0;
    logic [15:0] wr_data = 0;
    logic [15:0] rd_data;
    logic        wdg_rst;

    int total = 0, bad = 0;
    int slow_cyc = 0;
    int win_lo = -1, win_hi = -1;
    string win_req = "R1";
    int rise_cnt = 0, hi_len = 0;
    bit prev_rst = 0;

    iwdg_top i_iwdg_top (
        .clk(clk), .rst(rst), .lclk(lclk), .lrst(lrst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .wdg_rst(wdg_rst)
    );

    always #4 clk = ~clk;
    initial begin
        #3;
        forever begin lclk = ~lclk; #20; end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge lclk) slow_cyc++;

    // Reference timing model of the reset output, compared every slow clock.
    always @(negedge lclk) begin
        if (!lrst) begin
            if (wdg_rst && !prev_rst) begin
                rise_cnt++;
                if (rise_cnt > 1) chk(0, "R9", rise_cnt, 1);
                else chk(win_lo >= 0 && slow_cyc >= win_lo && slow_cyc <= win_hi,
                         win_req, slow_cyc, win_lo);
            end
            if (wdg_rst) hi_len++;
            if (!wdg_rst && prev_rst) chk(hi_len == 4, "R9", hi_len, 4);
            if (win_hi >= 0 && rise_cnt == 0 && slow_cyc > win_hi) begin
                chk(0, win_req, slow_cyc, win_hi);
                win_lo = -1;
                win_hi = -1;
            end
            prev_rst = wdg_rst;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1; lrst = 1;
        repeat (4) @(negedge lclk);
        win_lo = -1; win_hi = -1; win_req = "R1";
        rise_cnt = 0; hi_len = 0; prev_rst = 0;
        @(negedge lclk) lrst = 0;
        @(negedge clk) rst = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        rd_addr = a;
        #1 v = int'(rd_data);
    endtask

    task automatic wait_clear(input string req);
        int v;
        rd(2'd3, v);
        for (int n = 0; n < 30 && v != 0; n++) rd(2'd3, v);
        chk(v == 0, req, v, 0);
    endtask

    task automatic prog(input int pr, input int rl);
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'(pr));
        wait_clear("R3");
        wr(2'd2, 16'(rl));
        wait_clear("R4");
    endtask

    function automatic int divf(input int pr);
        return 4 << ((pr > 6) ? 6 : pr);
    endfunction

    task automatic arm_window(input int span, input string req);
        win_lo = slow_cyc + span + 1;
        win_hi = slow_cyc + span + 7;
        win_req = req;
    endtask

    task automatic wait_bite(input int limit);
        for (int n = 0; n < limit && !(rise_cnt > 0 && !prev_rst); n++) @(posedge lclk);
        repeat (20) @(posedge lclk);
    endtask

    task automatic run_timeout(input int pr, input int rl, input string req);
        do_reset();
        prog(pr, rl);
        arm_window(divf(pr) * rl, req);
        wr(2'd0, 16'hCCCC);
        wait_bite(divf(pr) * rl + 30);
        chk(rise_cnt == 1, req, rise_cnt, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v;
        // R1: reset state
        do_reset();
        rd(2'd1, v); chk(v == 0, "R1", v, 0);
        rd(2'd2, v); chk(v == 'hFFF, "R1", v, 'hFFF);
        rd(2'd3, v); chk(v == 0, "R1", v, 0);
        rd(2'd0, v); chk(v == 0, "R1", v, 0);
        repeat (300) @(negedge clk);
        chk(wdg_rst == 0 && rise_cnt == 0, "R1", rise_cnt, 0);

        // R2: locked writes ignored
        wr(2'd1, 16'd3);
        rd(2'd1, v); chk(v == 0, "R2", v, 0);
        rd(2'd3, v); chk(v == 0, "R2", v, 0);
        wr(2'd2, 16'h055);
        rd(2'd2, v); chk(v == 'hFFF, "R2", v, 'hFFF);

        // R3 / R4: pending flags
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd3);
        rd(2'd3, v); chk(v[0] == 1, "R3", v, 1);
        wait_clear("R3");
        rd(2'd1, v); chk(v == 3, "R3", v, 3);
        wr(2'd2, 16'h123);
        rd(2'd3, v); chk(v[1] == 1, "R4", v, 2);
        wait_clear("R4");
        rd(2'd2, v); chk(v == 'h123, "R4", v, 'h123);

        // R2: other key relocks
        wr(2'd0, 16'h1234);
        wr(2'd2, 16'h456);
        rd(2'd2, v); chk(v == 'h123, "R2", v, 'h123);

        // R5: back-to-back writes, second dropped
        wr(2'd0, 16'h5555);
        wr(2'd2, 16'h010);
        wr(2'd2, 16'h020);
        rd(2'd2, v); chk(v == 'h010, "R5", v, 'h010);
        wr(2'd1, 16'd1);
        wr(2'd1, 16'd2);
        rd(2'd1, v); chk(v == 1, "R5", v, 1);
        wait_clear("R5");

        // R6, R10, R11: timeouts
        run_timeout(0, 20, "R6");
        // R9: feeds after the pulse have no effect
        for (int k = 0; k < 3; k++) wr(2'd0, 16'hAAAA);
        repeat (100) @(posedge lclk);
        chk(rise_cnt == 1 && wdg_rst == 0, "R9", rise_cnt, 1);
        run_timeout(2, 10, "R6");
        run_timeout(6, 3, "R10");
        run_timeout(7, 3, "R10");
        run_timeout(0, 0, "R11");

        // R7: feeding holds off the reset
        do_reset();
        prog(0, 30);
        win_req = "R7";
        wr(2'd0, 16'hCCCC);
        for (int k = 0; k < 10; k++) begin
            repeat (60) @(posedge lclk);
            wr(2'd0, 16'hAAAA);
        end
        chk(rise_cnt == 0, "R7", rise_cnt, 0);
        repeat (20) @(posedge lclk);
        arm_window(4 * 30, "R7");
        wr(2'd0, 16'hAAAA);
        wait_bite(200);
        chk(rise_cnt == 1, "R7", rise_cnt, 1);

        // R8: keys cannot stop a running watchdog
        do_reset();
        prog(0, 25);
        arm_window(4 * 25, "R8");
        wr(2'd0, 16'hCCCC);
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h5555);
        wr(2'd2, 16'hFFF);
        wr(2'd0, 16'hFFFF);
        wait_bite(200);
        chk(rise_cnt == 1, "R8", rise_cnt, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule